// File: doc/BRIEF.md
# Platform System Control Register File

This block is a byte-wide register file reached through a simple I/O port decoder. It answers one stand-alone control port at 0x0092 and a window of 0x52 consecutive ports based at 0x0800. Its live state is small: a soft-reset request, an endian-mode flag, a disk activity indicator bit, a 4-bit system control field and an I/O map mode bit. Each of these drives a discrete output of the block.

Most of the window returns hard-wired board identity and equipment bytes. Two window addresses are write-triggered strobes that toggle the write lock of an external non-volatile memory. One of the two also reads back an identity byte. A host that writes to a window address that has no write behaviour sets a sticky error flag, which an integration bench can observe.

Reads are combinational: `bus_rdata` is valid in the same cycle as `bus_rd` and is zero while `bus_rd` is low. Writes take effect at the clock edge that samples `bus_wr`.

Top module: `sysctl_regfile`

## Requirements
- R1: A write to port 0x0092 sets `soft_reset` from data bit 0 (1 asserts, 0 releases) and `little_endian` from data bit 1. All other data bits are ignored.
- R2: A read of port 0x0092 returns `little_endian` in bit 1 and zero in every other bit.
- R3: Reads return these fixed bytes: 0x0800 gives 0xEF, 0x0802 gives 0xAD, 0x0803 gives 0xE0, 0x080C gives 0x3C, 0x0818 gives 0x00 and 0x0823 gives 0x03.
- R4: Port 0x0810 reads as 0x39. A write to it raises `nv_lock1` for exactly the one cycle after the write edge. A write to 0x0812 does the same on `nv_lock2`. Neither write touches the other strobe.
- R5: A write to 0x081C stores data bits 3:0 on `sys_ctrl`. A read of 0x081C returns that field, zero-extended.
- R6: A write to 0x0850 stores data bit 0 on `contig_map`. A read of 0x0850 returns that bit in bit 0 and zeros above it.
- R7: A write to 0x0808 sets or clears `disk_led` from data bit 0.
- R8: Writes to 0x0800, 0x0802 and 0x0803 change no output, do not set `wr_err`, and leave the read values of those ports unchanged.
- R9: A read of any window address not listed in R3 to R7 returns 0xFF. This includes 0x0808, 0x0812, 0x0814 and 0x0851.
- R10: A write to a window address with no write behaviour sets `wr_err`, and the flag holds until reset. A write to 0x0814 is accepted without effect and does not set the flag. The addresses with no write behaviour are 0x080C, 0x0818, 0x0823 and every address not named in R1 to R8.
- R11: While `bus_rd` is low, `bus_rdata` is 0x00. An address outside both the window and port 0x0092 reads as 0x00, and writes to it have no effect.
- R12: Reset clears every latched output to 0: reset released, big-endian, LED off, `sys_ctrl` 0, discontiguous map, strobes low, no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | I/O port address |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | 8 | Combinational read data |
| soft_reset | output | 1 | Soft reset request |
| little_endian | output | 1 | Endian mode flag, 1 = little |
| disk_led | output | 1 | Disk activity indicator |
| sys_ctrl | output | 4 | System control field |
| contig_map | output | 1 | I/O map mode, 1 = contiguous |
| nv_lock1 | output | 1 | Lock toggle strobe 1 |
| nv_lock2 | output | 1 | Lock toggle strobe 2 |
| wr_err | output | 1 | Sticky flag for writes to unsupported addresses |

## Verification
The checker assumes that `bus_rd` and `bus_wr` are never high together and that the inputs settle well before each sampling edge. It also assumes that no write is presented while reset is held, because its history-based properties compare output changes with the address and data of the previous cycle. The bench drives the bus only at falling edges, issues writes and reads as separate single-cycle operations, and keeps both strobes low throughout reset.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_P92,
      SEL_CPUCFG,
      SEL_FEAT,
      SEL_STAT,
      SEL_LED,
      SEL_EQUIP,
      SEL_XFEAT_LOCK1,
      SEL_LOCK2,
      SEL_L2INV,
      SEL_KEYLK,
      SEL_SCTL,
      SEL_L2PRES,
      SEL_MAP,
      SEL_OTHER
   } sel_e;

   // window offsets; software depends on these positions
   localparam int OFS_CPUCFG = 'h00;
   localparam int OFS_FEAT   = 'h02;
   localparam int OFS_STAT   = 'h03;
   localparam int OFS_LED    = 'h08;
   localparam int OFS_EQUIP  = 'h0C;
   localparam int OFS_XFEAT  = 'h10;
   localparam int OFS_LOCK2  = 'h12;
   localparam int OFS_L2INV  = 'h14;
   localparam int OFS_KEYLK  = 'h18;
   localparam int OFS_SCTL   = 'h1C;
   localparam int OFS_L2PRES = 'h23;
   localparam int OFS_MAP    = 'h50;

   // board identity bytes
   localparam logic [7:0] ID_CPUCFG = 8'hEF;
   localparam logic [7:0] ID_FEAT   = 8'hAD;
   localparam logic [7:0] ID_STAT   = 8'hE0;
   localparam logic [7:0] ID_EQUIP  = 8'h3C;
   localparam logic [7:0] ID_XFEAT  = 8'h39;
   localparam logic [7:0] ID_KEYLK  = 8'h00;
   localparam logic [7:0] ID_L2PRES = 8'h03;
   localparam logic [7:0] RD_EMPTY  = 8'hFF;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
   import sysctl_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int SPECIAL_PORT = 'h0092,
   parameter int WIN_BASE     = 'h0800,
   parameter int WIN_SIZE     = 'h52
) (
   input  logic [ADDR_W-1:0] addr,
   output sel_e              sel
);

   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(WIN_BASE);
   localparam logic [ADDR_W-1:0] SIZE_A = ADDR_W'(WIN_SIZE);
   localparam logic [ADDR_W-1:0] SPEC_A = ADDR_W'(SPECIAL_PORT);

   if (WIN_SIZE <= OFS_MAP) begin : g_bad_win
      $error("WIN_SIZE must cover the map mode register");
   end
   if (WIN_BASE + WIN_SIZE > (1 << ADDR_W)) begin : g_bad_span
      $error("window does not fit the address width");
   end

   logic [ADDR_W-1:0] ofs;
   logic              in_win;

   assign ofs    = addr - BASE_A;
   assign in_win = (addr >= BASE_A) && (ofs < SIZE_A);

   always_comb begin
      sel = SEL_NONE;
      if (addr == SPEC_A) begin
         sel = SEL_P92;
      end else if (in_win) begin
         case (ofs)
            ADDR_W'(OFS_CPUCFG): sel = SEL_CPUCFG;
            ADDR_W'(OFS_FEAT):   sel = SEL_FEAT;
            ADDR_W'(OFS_STAT):   sel = SEL_STAT;
            ADDR_W'(OFS_LED):    sel = SEL_LED;
            ADDR_W'(OFS_EQUIP):  sel = SEL_EQUIP;
            ADDR_W'(OFS_XFEAT):  sel = SEL_XFEAT_LOCK1;
            ADDR_W'(OFS_LOCK2):  sel = SEL_LOCK2;
            ADDR_W'(OFS_L2INV):  sel = SEL_L2INV;
            ADDR_W'(OFS_KEYLK):  sel = SEL_KEYLK;
            ADDR_W'(OFS_SCTL):   sel = SEL_SCTL;
            ADDR_W'(OFS_L2PRES): sel = SEL_L2PRES;
            ADDR_W'(OFS_MAP):    sel = SEL_MAP;
            default:             sel = SEL_OTHER;
         endcase
      end
   end

endmodule

// File: rtl/sysctl_ctrl_regs.sv
module sysctl_ctrl_regs
   import sysctl_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int SCTL_W     = 4,
   parameter bit STROBE_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  sel_e              sel,
   input  logic [DATA_W-1:0] wdata,
   output logic              soft_reset,
   output logic              little_endian,
   output logic              disk_led,
   output logic [SCTL_W-1:0] sys_ctrl,
   output logic              contig_map,
   output logic              nv_lock1,
   output logic              nv_lock2,
   output logic              wr_err
);

   logic unused_wdata;
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         soft_reset    <= 1'b0;
         little_endian <= 1'b0;
         disk_led      <= 1'b0;
         sys_ctrl      <= '0;
         contig_map    <= 1'b0;
         wr_err        <= 1'b0;
      end else if (wr) begin
         case (sel)
            SEL_P92: begin
               soft_reset    <= wdata[0];
               little_endian <= wdata[1];
            end
            SEL_LED:  disk_led   <= wdata[0];
            SEL_SCTL: sys_ctrl   <= wdata[SCTL_W-1:0];
            SEL_MAP:  contig_map <= wdata[0];
            SEL_EQUIP, SEL_KEYLK, SEL_L2PRES, SEL_OTHER: wr_err <= 1'b1;
            default: ;
         endcase
      end
   end

   logic hit1, hit2;
   assign hit1 = wr && (sel == SEL_XFEAT_LOCK1);
   assign hit2 = wr && (sel == SEL_LOCK2);

   if (STROBE_REG) begin : g_strobe_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            nv_lock1 <= 1'b0;
            nv_lock2 <= 1'b0;
         end else begin
            nv_lock1 <= hit1;
            nv_lock2 <= hit2;
         end
      end
   end else begin : g_strobe_comb
      assign nv_lock1 = hit1;
      assign nv_lock2 = hit2;
   end

endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
   import sysctl_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SCTL_W = 4
) (
   input  logic              rd,
   input  sel_e              sel,
   input  logic              little_endian,
   input  logic [SCTL_W-1:0] sys_ctrl,
   input  logic              contig_map,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] val;

   always_comb begin
      val = '0;
      case (sel)
         SEL_P92:         val[1] = little_endian;
         SEL_CPUCFG:      val = DATA_W'(ID_CPUCFG);
         SEL_FEAT:        val = DATA_W'(ID_FEAT);
         SEL_STAT:        val = DATA_W'(ID_STAT);
         SEL_EQUIP:       val = DATA_W'(ID_EQUIP);
         SEL_XFEAT_LOCK1: val = DATA_W'(ID_XFEAT);
         SEL_KEYLK:       val = DATA_W'(ID_KEYLK);
         SEL_L2PRES:      val = DATA_W'(ID_L2PRES);
         SEL_SCTL:        val = DATA_W'(sys_ctrl);
         SEL_MAP:         val[0] = contig_map;
         SEL_NONE:        val = '0;
         default:         val = DATA_W'(RD_EMPTY);
      endcase
   end

   assign rdata = rd ? val : '0;

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
   import sysctl_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int DATA_W       = 8,
   parameter int SCTL_W       = 4,
   parameter int SPECIAL_PORT = 'h0092,
   parameter int WIN_BASE     = 'h0800,
   parameter int WIN_SIZE     = 'h52,
   parameter bit STROBE_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   input  logic              bus_wr,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              soft_reset,
   output logic              little_endian,
   output logic              disk_led,
   output logic [SCTL_W-1:0] sys_ctrl,
   output logic              contig_map,
   output logic              nv_lock1,
   output logic              nv_lock2,
   output logic              wr_err
);

   if (DATA_W != 8) begin : g_bad_dw
      $error("DATA_W must be 8 for this port set");
   end
   if (SCTL_W < 1 || SCTL_W > DATA_W) begin : g_bad_sctl
      $error("SCTL_W out of range");
   end

   sel_e sel;

   sysctl_decode #(
      .ADDR_W(ADDR_W), .SPECIAL_PORT(SPECIAL_PORT),
      .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)
   ) u_dec (
      .addr(bus_addr),
      .sel (sel)
   );

   sysctl_ctrl_regs #(
      .DATA_W(DATA_W), .SCTL_W(SCTL_W), .STROBE_REG(STROBE_REG)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr           (bus_wr),
      .sel          (sel),
      .wdata        (bus_wdata),
      .soft_reset   (soft_reset),
      .little_endian(little_endian),
      .disk_led     (disk_led),
      .sys_ctrl     (sys_ctrl),
      .contig_map   (contig_map),
      .nv_lock1     (nv_lock1),
      .nv_lock2     (nv_lock2),
      .wr_err       (wr_err)
   );

   sysctl_rdmux #(
      .DATA_W(DATA_W), .SCTL_W(SCTL_W)
   ) u_rd (
      .rd           (bus_rd),
      .sel          (sel),
      .little_endian(little_endian),
      .sys_ctrl     (sys_ctrl),
      .contig_map   (contig_map),
      .rdata        (bus_rdata)
   );

endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk #(
   parameter int ADDR_W       = 16,
   parameter int DATA_W       = 8,
   parameter int SCTL_W       = 4,
   parameter int SPECIAL_PORT = 'h0092,
   parameter int WIN_BASE     = 'h0800,
   parameter bit STROBE_REG   = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              soft_reset,
   input logic              little_endian,
   input logic              disk_led,
   input logic [SCTL_W-1:0] sys_ctrl,
   input logic              contig_map,
   input logic              nv_lock1,
   input logic              nv_lock2,
   input logic              wr_err
);

   localparam logic [ADDR_W-1:0] A_SPEC = ADDR_W'(SPECIAL_PORT);
   localparam logic [ADDR_W-1:0] A_CPU  = ADDR_W'(WIN_BASE);
   localparam logic [ADDR_W-1:0] A_LCK1 = ADDR_W'(WIN_BASE + 'h10);
   localparam logic [ADDR_W-1:0] A_LCK2 = ADDR_W'(WIN_BASE + 'h12);
   localparam logic [ADDR_W-1:0] A_SCTL = ADDR_W'(WIN_BASE + 'h1C);
   localparam logic [ADDR_W-1:0] A_MAP  = ADDR_W'(WIN_BASE + 'h50);

   logic unused_chk;
   assign unused_chk = disk_led;

   AST_RST_FROM_SPECIAL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(soft_reset) |-> $past(bus_wr && bus_addr == A_SPEC) && (soft_reset == $past(bus_wdata[0]))); // R1

   AST_ENDIAN_FROM_SPECIAL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(little_endian) |-> $past(bus_wr && bus_addr == A_SPEC)); // R1

   AST_SPECIAL_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == A_SPEC) |-> bus_rdata == DATA_W'({little_endian, 1'b0})); // R2

   AST_CPUCFG_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == A_CPU) |-> bus_rdata == DATA_W'(8'hEF)); // R3

   AST_SCTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sys_ctrl) |-> $past(bus_wr && bus_addr == A_SCTL) && (sys_ctrl == $past(bus_wdata[SCTL_W-1:0]))); // R5

   AST_MAP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(contig_map) |-> $past(bus_wr && bus_addr == A_MAP)); // R6

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(wr_err)); // R10

   AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> bus_rdata == '0); // R11

   if (STROBE_REG) begin : g_strobe_chk
      AST_LOCK1_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         nv_lock1 |-> $past(bus_wr && bus_addr == A_LCK1)); // R4
      AST_LOCK2_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         nv_lock2 |-> $past(bus_wr && bus_addr == A_LCK2)); // R4
   end

endmodule

bind sysctl_regfile sysctl_regfile_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SCTL_W(SCTL_W),
   .SPECIAL_PORT(SPECIAL_PORT), .WIN_BASE(WIN_BASE), .STROBE_REG(STROBE_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
   .soft_reset(soft_reset), .little_endian(little_endian), .disk_led(disk_led),
   .sys_ctrl(sys_ctrl), .contig_map(contig_map), .nv_lock1(nv_lock1),
   .nv_lock2(nv_lock2), .wr_err(wr_err)
);

// File: tb/sysctl_regfile_tb.sv
module sysctl_regfile_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 30;

   typedef struct packed {
      logic        is_wr;
      logic [15:0] addr;
      logic [7:0]  data;
   } vec_t;

   // writes carry data, reads carry the expected byte
   localparam vec_t [0:NV-1] VECS = '{
      '{1'b0, 16'h0092, 8'h00},   // R2 reset value
      '{1'b0, 16'h0800, 8'hEF},   // R3
      '{1'b0, 16'h0802, 8'hAD},   // R3
      '{1'b0, 16'h0803, 8'hE0},   // R3
      '{1'b0, 16'h080C, 8'h3C},   // R3
      '{1'b0, 16'h0818, 8'h00},   // R3
      '{1'b0, 16'h0823, 8'h03},   // R3
      '{1'b0, 16'h0810, 8'h39},   // R4
      '{1'b0, 16'h081C, 8'h00},   // R5 reset
      '{1'b0, 16'h0850, 8'h00},   // R6 reset
      '{1'b0, 16'h0814, 8'hFF},   // R9
      '{1'b0, 16'h0808, 8'hFF},   // R9
      '{1'b0, 16'h0812, 8'hFF},   // R9
      '{1'b0, 16'h0851, 8'hFF},   // R9
      '{1'b0, 16'h0801, 8'hFF},   // R9
      '{1'b1, 16'h0800, 8'h55},   // R8
      '{1'b0, 16'h0800, 8'hEF},   // R8
      '{1'b1, 16'h0803, 8'h00},   // R8
      '{1'b0, 16'h0803, 8'hE0},   // R8
      '{1'b1, 16'h081C, 8'hA7},   // R5
      '{1'b0, 16'h081C, 8'h07},   // R5
      '{1'b1, 16'h0850, 8'h03},   // R6
      '{1'b0, 16'h0850, 8'h01},   // R6
      '{1'b1, 16'h0092, 8'h02},   // R1
      '{1'b0, 16'h0092, 8'h02},   // R2
      '{1'b1, 16'h0850, 8'hFE},   // R6
      '{1'b0, 16'h0850, 8'h00},   // R6
      '{1'b0, 16'h0852, 8'h00},   // R11 past window
      '{1'b0, 16'h07FF, 8'h00},   // R11 below window
      '{1'b0, 16'h0091, 8'h00}    // R11
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_rdata;
   logic        soft_reset, little_endian, disk_led, contig_map;
   logic [3:0]  sys_ctrl;
   logic        nv_lock1, nv_lock2, wr_err;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sysctl_regfile u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
      .soft_reset(soft_reset), .little_endian(little_endian), .disk_led(disk_led),
      .sys_ctrl(sys_ctrl), .contig_map(contig_map), .nv_lock1(nv_lock1),
      .nv_lock2(nv_lock2), .wr_err(wr_err)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic do_read(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      bus_rd   = 1'b1;
      #1;
      d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic check_all_clear(input string tag);
      check(tag, {7'b0, soft_reset, little_endian, disk_led, sys_ctrl, contig_map, wr_err},
            16'h0000);
      check({tag, " strobes"}, {14'b0, nv_lock1, nv_lock2}, 16'h0000);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] rv;
      repeat (3) @(negedge clk);
      check_all_clear("R12 reset state");
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 idle rdata", {8'h00, bus_rdata}, 16'h0000);

      for (int i = 0; i < NV; i++) begin
         if (VECS[i].is_wr) begin
            do_write(VECS[i].addr, VECS[i].data);
         end else begin
            do_read(VECS[i].addr, rv);
            check($sformatf("table[%0d] read %h", i, VECS[i].addr), {8'h00, rv},
                  {8'h00, VECS[i].data});
         end
      end
      check("R8 no error from read-only writes", {15'b0, wr_err}, 16'h0000);

      // R1: reset bit and endian bit, upper bits ignored
      do_write(16'h0092, 8'h01);
      check("R1 reset asserted", {14'b0, soft_reset, little_endian}, 16'h0002);
      do_write(16'h0092, 8'hFE);
      check("R1 reset released endian set", {14'b0, soft_reset, little_endian}, 16'h0001);
      do_read(16'h0092, rv);
      check("R2 read special port", {8'h00, rv}, 16'h0002);
      do_write(16'h0092, 8'h00);
      check("R1 endian cleared", {15'b0, little_endian}, 16'h0000);

      // R7 indicator
      do_write(16'h0808, 8'h01);
      check("R7 led on", {15'b0, disk_led}, 16'h0001);
      do_write(16'h0808, 8'hFE);
      check("R7 led off", {15'b0, disk_led}, 16'h0000);

      // R4 strobes
      do_write(16'h0810, 8'h00);
      check("R4 lock1 pulse", {14'b0, nv_lock1, nv_lock2}, 16'h0002);
      @(negedge clk);
      check("R4 lock1 single cycle", {14'b0, nv_lock1, nv_lock2}, 16'h0000);
      do_write(16'h0812, 8'hFF);
      check("R4 lock2 pulse", {14'b0, nv_lock1, nv_lock2}, 16'h0001);
      @(negedge clk);
      check("R4 lock2 single cycle", {14'b0, nv_lock1, nv_lock2}, 16'h0000);

      // R10 accepted no-op, R11 outside window
      do_write(16'h0814, 8'hFF);
      check("R10 0x814 write no error", {15'b0, wr_err}, 16'h0000);
      do_write(16'h0900, 8'hFF);
      check("R11 outside write no effect", {8'b0, soft_reset, little_endian, disk_led,
            contig_map, sys_ctrl}, 16'h0007);
      check("R11 outside write no error", {15'b0, wr_err}, 16'h0000);
      do_write(16'h0823, 8'h00);
      check("R10 error set", {15'b0, wr_err}, 16'h0001);
      do_write(16'h081C, 8'h03);
      check("R10 error sticky", {15'b0, wr_err}, 16'h0001);
      check("R5 field rewritten", {12'b0, sys_ctrl}, 16'h0003);

      // R12 reset with state held
      do_write(16'h0850, 8'h01);
      do_write(16'h0092, 8'h03);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check_all_clear("R12 reset mid-run");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      do_read(16'h081C, rv);
      check("R12 field cleared", {8'h00, rv}, 16'h0000);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule